// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

This block is a bank of sixteen general-purpose pins on a small 32-bit register bus. Every pin carries a direction bit, a drive bit and a synchronised input level. It also has an edge detector that can watch for rising edges, falling edges, both, or neither. The edges it catches collect in an event register that software clears by writing ones. A single level interrupt line stays high while any captured event is also armed.

Software can write the drive bits and the arm bits whole. It can also change them one bit at a time through separate set and clear alias addresses, so it never needs a read-modify-write sequence that could race with another agent. A read-only identity register reports a major and a minor version. Reads are combinational from the address. A write takes effect at the rising clock edge on which the write enable is high.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, all pins are inputs (direction reads 0xFFFF and `pin_oe` is 0). The drive, arm, event and both sense registers read 0, and `irq` is low.
- R2: The direction register at 0x14 holds one bit per pin. A 1 makes the pin an input (`pin_oe` bit 0). A 0 makes it an output (`pin_oe` bit 1), driven with the drive bit.
- R3: A write to the drive register at 0x08 replaces all sixteen drive bits, ignores write data bits 31:16, and appears on `pin_out`. A read at 0x08 returns the drive bits.
- R4: A write to 0x0C sets each drive bit whose write data bit is 1 and leaves the others unchanged. Reads of 0x0C return 0.
- R5: A write to 0x10 clears each drive bit whose write data bit is 1 and leaves the others unchanged. Writing all zeros changes nothing.
- R6: The arm register at 0x24 is written whole. Writes to 0x28 set the arm bits marked with a 1, and writes to 0x2C clear them. Bits marked with a 0 are unchanged.
- R7: A read at 0x04 returns the pin inputs through a two-flop synchroniser. A change applied before rising edge k becomes visible after rising edge k+1.
- R8: Each pin has a 2-bit sense field. Pins 0–7 are in the register at 0x18 and pins 8–15 in the register at 0x1C. Pin n uses bits [2(n mod 8)+1 : 2(n mod 8)]. The encodings are 00 no detection, 01 rising, 10 falling, 11 both.
- R9: A detected edge sets the pin's bit in the event register at 0x20, whatever its arm bit is. Writing 1 to a bit there clears it, and writing 0 leaves it alone. The bit is set at the third rising edge after the input change.
- R10: When an edge and a clearing write hit the same event bit in the same cycle, the bit ends set.
- R11: `irq` is high exactly while some event bit and its arm bit are both 1.
- R12: The identity register at 0x00 reads major version in bits [7:4] and minor in bits [3:0] (0x21 by default) and ignores writes; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Drive value to the pads |
| pin_oe | output | 16 | Pad output enable, 1 = drive |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the latency of the input path. The event bit must appear on the third clock edge and not the second; a design with one synchroniser stage too few or too many fails that exact-cycle sample. It checks that each sense field sits at its own pin's bit pair and that each of the four encodings reacts to the right edge. A swapped bit or a shifted field would flag the wrong pin or miss the edge. The collision of a clearing write with a fresh edge in the same cycle is forced, so a design that gives the write priority loses the event. The aliases are checked to leave unmarked bits alone, so a plain overwrite through them shows up at once.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam logic [7:0] OFS_IDENT    = 8'h00;
  localparam logic [7:0] OFS_LEVEL    = 8'h04;
  localparam logic [7:0] OFS_DRIVE    = 8'h08;
  localparam logic [7:0] OFS_DRV_SET  = 8'h0C;
  localparam logic [7:0] OFS_DRV_CLR  = 8'h10;
  localparam logic [7:0] OFS_DIR      = 8'h14;
  localparam logic [7:0] OFS_SENSE_LO = 8'h18;
  localparam logic [7:0] OFS_SENSE_HI = 8'h1C;
  localparam logic [7:0] OFS_EVENT    = 8'h20;
  localparam logic [7:0] OFS_ARM      = 8'h24;
  localparam logic [7:0] OFS_ARM_SET  = 8'h28;
  localparam logic [7:0] OFS_ARM_CLR  = 8'h2C;

  // Per-pin sense field: bit 0 selects rising edges, bit 1 falling edges.
  typedef enum logic [1:0] {
    SENSE_NONE = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   level,
  input  logic [2*PINS-1:0] sense,
  output logic [PINS-1:0]   hit
);
  import gpio_pkg::*;

  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    sense_e mode;
    logic   rise;
    logic   fall;
    always_comb begin
      mode = sense_e'(sense[2*i +: 2]);
      rise = level[i] & ~prev_q[i];
      fall = ~level[i] & prev_q[i];
      unique case (mode)
        SENSE_RISE: hit[i] = rise;
        SENSE_FALL: hit[i] = fall;
        SENSE_BOTH: hit[i] = rise | fall;
        default:    hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int PINS    = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int VER_MAJ = 2,
  parameter int VER_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  import gpio_pkg::*;

  localparam int HALF = PINS / 2;
  localparam int FW   = 2 * HALF;

  logic            rst_sync_n;
  logic [PINS-1:0] level;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] wdat;

  logic [PINS-1:0] drive_q, drive_d;
  logic [PINS-1:0] dir_q,   dir_d;
  logic [PINS-1:0] arm_q,   arm_d;
  logic [PINS-1:0] event_q, event_d;
  logic [FW-1:0]   sense_lo_q, sense_lo_d;
  logic [FW-1:0]   sense_hi_q, sense_hi_d;

  logic wr_drive, wr_dset, wr_dclr, wr_dir;
  logic wr_arm, wr_aset, wr_aclr, wr_event, wr_slo, wr_shi;
  logic drive_en, arm_en, dir_en, slo_en, shi_en;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:PINS];

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (level)
  );

  gpio_edge_detect #(.PINS(PINS)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .level (level),
    .sense ({sense_hi_q, sense_lo_q}),
    .hit   (hit)
  );

  // Write decode
  always_comb begin
    wdat     = bus_wdata[PINS-1:0];
    wr_drive = bus_we && (bus_addr == ADDR_W'(OFS_DRIVE));
    wr_dset  = bus_we && (bus_addr == ADDR_W'(OFS_DRV_SET));
    wr_dclr  = bus_we && (bus_addr == ADDR_W'(OFS_DRV_CLR));
    wr_dir   = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
    wr_arm   = bus_we && (bus_addr == ADDR_W'(OFS_ARM));
    wr_aset  = bus_we && (bus_addr == ADDR_W'(OFS_ARM_SET));
    wr_aclr  = bus_we && (bus_addr == ADDR_W'(OFS_ARM_CLR));
    wr_event = bus_we && (bus_addr == ADDR_W'(OFS_EVENT));
    wr_slo   = bus_we && (bus_addr == ADDR_W'(OFS_SENSE_LO));
    wr_shi   = bus_we && (bus_addr == ADDR_W'(OFS_SENSE_HI));
  end

  // Next-state and clock enables
  always_comb begin
    drive_en = wr_drive | wr_dset | wr_dclr;
    arm_en   = wr_arm | wr_aset | wr_aclr;
    dir_en   = wr_dir;
    slo_en   = wr_slo;
    shi_en   = wr_shi;

    if (wr_drive)     drive_d = wdat;
    else if (wr_dset) drive_d = drive_q | wdat;
    else              drive_d = drive_q & ~wdat;

    if (wr_arm)       arm_d = wdat;
    else if (wr_aset) arm_d = arm_q | wdat;
    else              arm_d = arm_q & ~wdat;

    dir_d      = wdat;
    sense_lo_d = bus_wdata[FW-1:0];
    sense_hi_d = bus_wdata[FW-1:0];

    // A fresh edge outranks a clearing write to the same bit.
    event_d = (event_q & ~(wr_event ? wdat : '0)) | hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      drive_q    <= '0;
      dir_q      <= '1;
      arm_q      <= '0;
      event_q    <= '0;
      sense_lo_q <= '0;
      sense_hi_q <= '0;
    end else begin
      if (drive_en) drive_q    <= drive_d;
      if (dir_en)   dir_q      <= dir_d;
      if (arm_en)   arm_q      <= arm_d;
      if (slo_en)   sense_lo_q <= sense_lo_d;
      if (shi_en)   sense_hi_q <= sense_hi_d;
      event_q <= event_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_IDENT):    bus_rdata = DATA_W'({4'(VER_MAJ), 4'(VER_MIN)});
      ADDR_W'(OFS_LEVEL):    bus_rdata = DATA_W'(level);
      ADDR_W'(OFS_DRIVE):    bus_rdata = DATA_W'(drive_q);
      ADDR_W'(OFS_DIR):      bus_rdata = DATA_W'(dir_q);
      ADDR_W'(OFS_SENSE_LO): bus_rdata = DATA_W'(sense_lo_q);
      ADDR_W'(OFS_SENSE_HI): bus_rdata = DATA_W'(sense_hi_q);
      ADDR_W'(OFS_EVENT):    bus_rdata = DATA_W'(event_q);
      ADDR_W'(OFS_ARM):      bus_rdata = DATA_W'(arm_q);
      default:               bus_rdata = '0;
    endcase
  end

  assign pin_out = drive_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |(event_q & arm_q);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [PINS-1:0]   wdat,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   event_q,
  input logic [PINS-1:0]   hit,
  input logic              irq
);
  import gpio_pkg::*;

  logic w_dir, w_set, w_clr, w_evt;
  assign w_dir = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
  assign w_set = bus_we && (bus_addr == ADDR_W'(OFS_DRV_SET));
  assign w_clr = bus_we && (bus_addr == ADDR_W'(OFS_DRV_CLR));
  assign w_evt = bus_we && (bus_addr == ADDR_W'(OFS_EVENT));

  // R2: a direction write shows up inverted on the output enables
  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(w_dir)) |-> (pin_oe == ~$past(wdat)));

  // R4: set alias raises marked bits, keeps the rest
  a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(w_set)) |->
      (((pin_out & $past(wdat)) == $past(wdat)) &&
       ((pin_out & ~$past(wdat)) == ($past(pin_out) & ~$past(wdat)))));

  // R5: clear alias drops marked bits, keeps the rest
  a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(w_clr)) |->
      (((pin_out & $past(wdat)) == '0) &&
       ((pin_out & ~$past(wdat)) == ($past(pin_out) & ~$past(wdat)))));

  // R9: an event bit only drops through a write of 1 to it
  a_r9_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |->
      (($past(event_q) & ~event_q & ~($past(w_evt) ? $past(wdat) : '0)) == '0));

  // R10: a detected edge always lands in the event register
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(hit != '0)) |-> ((event_q & $past(hit)) == $past(hit)));

  // R11: a full clear with no edge leaves the interrupt low
  a_r11_quiet_after_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(w_evt && (wdat == '1) && (hit == '0))) |-> !irq);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .wdat       (wdat),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .event_q    (event_q),
  .hit        (hit),
  .irq        (irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {write addr, write data, read addr, expected read, requirement number}
  typedef logic [87:0] vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    {8'h08, 32'hFFFF_A5A5, 8'h08, 32'h0000_A5A5, 8'd3},   // R3 upper bits ignored
    {8'h0C, 32'h0000_0F00, 8'h08, 32'h0000_AFA5, 8'd4},   // R4 set alias
    {8'h10, 32'h0000_0005, 8'h08, 32'h0000_AFA0, 8'd5},   // R5 clear alias
    {8'h10, 32'h0000_0000, 8'h08, 32'h0000_AFA0, 8'd5},   // R5 zero write no-op
    {8'h14, 32'h0000_00FF, 8'h14, 32'h0000_00FF, 8'd2},   // R2 direction readback
    {8'h24, 32'h0000_1234, 8'h24, 32'h0000_1234, 8'd6},   // R6 arm direct
    {8'h28, 32'h0000_8001, 8'h24, 32'h0000_9235, 8'd6},   // R6 arm set
    {8'h2C, 32'h0000_1004, 8'h24, 32'h0000_8231, 8'd6},   // R6 arm clear
    {8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_0021, 8'd12},  // R12 identity read-only
    {8'h0C, 32'h0000_0000, 8'h0C, 32'h0000_0000, 8'd4},   // R4 alias reads zero
    {8'h18, 32'h0001_E4E4, 8'h18, 32'h0000_E4E4, 8'd8},   // R8 sense field width
    {8'h40, 32'hDEAD_BEEF, 8'h40, 32'h0000_0000, 8'd12}   // R12 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    reset_dut();

    // R1 reset state
    rd(8'h14, v); check("R1 dir", v, 32'h0000_FFFF);
    rd(8'h08, v); check("R1 drive", v, 32'h0);
    rd(8'h24, v); check("R1 arm", v, 32'h0);
    rd(8'h20, v); check("R1 event", v, 32'h0);
    rd(8'h18, v); check("R1 sense lo", v, 32'h0);
    rd(8'h1C, v); check("R1 sense hi", v, 32'h0);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t e;
      e = VECS[i];
      wr(e[87:80], e[79:48]);
      rd(e[47:40], v);
      check($sformatf("R%0d vec%0d", e[7:0], i), v, e[39:8]);
      @(negedge clk);
    end

    reset_dut();

    // R2 / R3 pads
    wr(8'h14, 32'h0000_FFF0);
    wr(8'h08, 32'h0000_000A);
    check("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_000F);
    check("R3 pin_out", {16'h0, pin_out}, 32'h0000_000A);

    // R7 synchroniser latency
    pin_in = 16'h0001;
    @(negedge clk); rd(8'h04, v); check("R7 level after 1 edge", v, 32'h0);
    @(negedge clk); rd(8'h04, v); check("R7 level after 2 edges", v, 32'h1);
    pin_in = 16'h0000; wait_n(4);
    wr(8'h20, 32'h0000_FFFF);

    // R8 sense: pin0 rising, pin9 falling (hi [3:2]=10), pin15 both (hi [15:14]=11), pin1 none
    wr(8'h18, 32'h0000_0001);
    wr(8'h1C, 32'h0000_C008);
    pin_in = 16'h0003;
    wait_n(2); rd(8'h20, v); check("R9 event not yet at edge 2", v, 32'h0);
    @(negedge clk); rd(8'h20, v); check("R9 event at edge 3", v, 32'h0000_0001);
    check("R11 irq low when unarmed", {31'h0, irq}, 32'h0);
    pin_in = 16'h8203; wait_n(4);
    rd(8'h20, v); check("R8 rising on both-mode only", v, 32'h0000_8001);
    wr(8'h20, 32'h0000_0001);
    rd(8'h20, v); check("R9 write-1 clears one bit", v, 32'h0000_8000);
    pin_in = 16'h0000; wait_n(4);
    rd(8'h20, v); check("R8 falling edges", v, 32'h0000_8200);

    // R11 interrupt
    wr(8'h24, 32'h0000_0200);
    check("R11 irq armed", {31'h0, irq}, 32'h1);
    wr(8'h20, 32'h0000_0200);
    check("R11 irq after clear", {31'h0, irq}, 32'h0);
    wr(8'h24, 32'h0000_FFFF);
    wr(8'h20, 32'h0000_FFFF);
    pin_in = 16'h8000;
    wait_n(2); check("R11 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R11 irq at edge 3", {31'h0, irq}, 32'h1);

    // R10 edge beats a clearing write in the same cycle
    pin_in = 16'h0000;
    wait_n(2);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h20, v); check("R10 edge wins", v, 32'h0000_8000);
    check("R10 irq stays", {31'h0, irq}, 32'h1);

    summary();
  end
endmodule